// File: doc/BRIEF.md
# Dual-Path Flash Address Mapper

This block turns CPU-side Flash requests into physical word addresses for a paged, word-organised Flash array. It accepts requests from two paths. The code-space path forms an extended pointer from an extension byte placed above a 16-bit pointer. The data-space path sees Flash through a 32 KB window at 0x8000 in a 16-bit data address space. A block-select field chooses which 32 KB slice of Flash appears in that window. Both paths return one byte per read, and the byte is picked from the 16-bit word the array returns.

Read requests arrive on two valid/ready request streams and share one valid/ready response stream. A request is taken when its valid and ready are both high at a rising edge. The mapper raises a request ready only when the response slot is empty or is being drained in the same cycle. While the consumer holds the response ready low, the response is held unchanged. A request stays pending as long as its valid is held, and it needs no timing from the consumer.

Programming is plain control. A start pulse latches the page and word-in-page of the code pointer and sets a busy flag. The busy flag stays set until a done pulse arrives, so the pointer can move on while the operation runs.

Top module: `flash_addr_mapper`

## Requirements
- R1: A code read addresses Flash word bits [16:1] of the pointer {ext, ptr}, with default 65536 words. Extension bits above that range have no effect on the word address.
- R2: Code read byte lane: pointer bit 0 = 0 returns word bits [7:0], and 1 returns word bits [15:8].
- R3: A data address with bit 15 = 0 is a miss. On a miss, dr_hit stays low, dr_ready stays low and no Flash read is issued. With bit 15 = 1, dr_hit is high whenever dr_valid is high.
- R4: A data read uses byte offset blk*32768 + (addr - 0x8000). The Flash word is offset bits [16:1] and the byte lane is offset bit 0, with the same lane rule as R2.
- R5: rsp_valid is high in the cycle after a request is accepted, and its data is the byte for that request.
- R6: A request ready is high only when rsp_valid is low or rsp_ready is high. While rsp_valid is high and rsp_ready is low, rsp_valid and rsp_data hold. Responses come out in request order.
- R7: When both request paths are valid in the same cycle, the code path is accepted and dr_ready is low.
- R8: pg_start while idle latches page = word[15:6] and word index = word[5:0] of the code pointer, ignores pointer bit 0, and sets pg_busy in the next cycle.
- R9: pg_start while pg_busy is high is ignored. The latched page and index keep their values.
- R10: pg_done while busy clears pg_busy in the next cycle, and a later pg_start is latched again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cr_valid | input | 1 | Code read request valid |
| cr_ready | output | 1 | Code read request ready |
| cr_ext | input | EXT_W | Code pointer extension byte |
| cr_ptr | input | 16 | Code pointer low 16 bits |
| dr_valid | input | 1 | Data read request valid |
| dr_ready | output | 1 | Data read request ready |
| dr_addr | input | 16 | Data-space byte address |
| dr_blk | input | BLK_W | Block shown in the data window |
| dr_hit | output | 1 | Data request falls inside the Flash window |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 8 | Response byte |
| fl_rd_en | output | 1 | Flash array read strobe |
| fl_rd_addr | output | WA_W | Flash word address for the read |
| fl_rd_data | input | 16 | Flash word, one cycle after fl_rd_en |
| pg_start | input | 1 | Programming start pulse |
| pg_ext | input | EXT_W | Programming pointer extension |
| pg_ptr | input | 16 | Programming pointer low 16 bits |
| pg_done | input | 1 | Programming finished pulse |
| pg_busy | output | 1 | Programming operation in progress |
| pg_page | output | PAGE_W | Latched page number |
| pg_widx | output | WIP_W | Latched word index in page |

## Verification
The code path is tried with even and odd pointers and with extension bytes that differ only above the array. This separates lane selection from address forming and shows that the high bits are masked. The data path is tried in every block, at both ends of the window, and with addresses just below 0x8000. This separates the block arithmetic and the window decode. Simultaneous requests and a consumer that stalls two cycles in three show up faults in priority, ordering and the hold behaviour. Programming is tried with an odd pointer, a pointer change together with a start while busy, and a restart after done.

// File: rtl/flmap_pkg.sv
package flmap_pkg;
  typedef enum logic {SRC_CODE = 1'b0, SRC_DATA = 1'b1} src_e;

  function automatic logic [7:0] lane_pick(input logic [15:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction
endpackage

// File: rtl/flmap_code_xlat.sv
module flmap_code_xlat #(
  parameter int EXT_W  = 8,
  parameter int WIP_W  = 6,
  parameter int PAGE_W = 10,
  localparam int WA_W  = WIP_W + PAGE_W
) (
  input  logic [EXT_W-1:0]  ext,
  input  logic [15:0]       ptr,
  output logic [WA_W-1:0]   word_addr,
  output logic              lane,
  output logic [PAGE_W-1:0] page,
  output logic [WIP_W-1:0]  widx
);
  localparam int PTR_W = EXT_W + 16;
  logic [PTR_W-1:0] full;

  assign full      = {ext, ptr};
  assign lane      = full[0];
  assign word_addr = full[WA_W:1];
  assign page      = word_addr[WA_W-1:WIP_W];
  assign widx      = word_addr[WIP_W-1:0];
endmodule

// File: rtl/flmap_data_xlat.sv
module flmap_data_xlat #(
  parameter int WA_W  = 16,
  parameter int BLK_W = 2
) (
  input  logic [15:0]      addr,
  input  logic [BLK_W-1:0] blk,
  output logic             in_win,
  output logic [WA_W-1:0]  word_addr,
  output logic             lane
);
  localparam int BA_W = WA_W + 1;
  logic [BA_W-1:0] offs;

  assign in_win = addr[15];

  generate
    if (BA_W > 15) begin : g_banked
      logic [BLK_W+14:0] wide;
      assign wide = {blk, addr[14:0]};
      assign offs = wide[BA_W-1:0];
    end else begin : g_flat
      logic unused_blk;
      assign unused_blk = ^blk;
      assign offs = addr[BA_W-1:0];
    end
  endgenerate

  assign lane      = offs[0];
  assign word_addr = offs[BA_W-1:1];
endmodule

// File: rtl/flmap_rd_stage.sv
module flmap_rd_stage
  import flmap_pkg::*;
#(
  parameter int WA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            code_req,
  input  logic [WA_W-1:0] code_word,
  input  logic            code_lane,
  input  logic            data_req,
  input  logic [WA_W-1:0] data_word,
  input  logic            data_lane,
  output logic            code_ready,
  output logic            data_ready,
  output logic            fl_rd_en,
  output logic [WA_W-1:0] fl_rd_addr,
  input  logic [15:0]     fl_rd_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [7:0]      rsp_data
);
  src_e       src;
  logic       slot_free;
  logic       take;
  logic       fresh_q;
  logic       lane_q;
  logic [7:0] hold_q;
  logic [7:0] live_byte;

  assign slot_free  = !rsp_valid || rsp_ready;
  assign src        = code_req ? SRC_CODE : SRC_DATA;
  assign code_ready = slot_free;
  assign data_ready = slot_free && !code_req;
  assign take       = slot_free && (code_req || data_req);
  assign fl_rd_en   = take;
  assign fl_rd_addr = (src == SRC_CODE) ? code_word : data_word;
  assign live_byte  = lane_pick(fl_rd_data, lane_q);
  assign rsp_data   = fresh_q ? live_byte : hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      fresh_q   <= 1'b0;
      lane_q    <= 1'b0;
      hold_q    <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      fresh_q   <= 1'b1;
      lane_q    <= (src == SRC_CODE) ? code_lane : data_lane;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
      fresh_q   <= 1'b0;
    end else if (fresh_q) begin
      hold_q  <= live_byte;
      fresh_q <= 1'b0;
    end
  end

  a_r5_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd_en |=> rsp_valid);
  a_r6_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
  a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !fl_rd_en);
endmodule

// File: rtl/flmap_pg_latch.sv
module flmap_pg_latch #(
  parameter int WIP_W  = 6,
  parameter int PAGE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              done,
  input  logic [PAGE_W-1:0] page_in,
  input  logic [WIP_W-1:0]  widx_in,
  output logic              busy,
  output logic [PAGE_W-1:0] page_q,
  output logic [WIP_W-1:0]  widx_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      page_q <= '0;
      widx_q <= '0;
    end else if (busy) begin
      if (done) busy <= 1'b0;
    end else if (start) begin
      busy   <= 1'b1;
      page_q <= page_in;
      widx_q <= widx_in;
    end
  end

  a_r9_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy && $stable(page_q) && $stable(widx_q)));
  a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done) |=> !busy);
  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/flash_addr_mapper.sv
module flash_addr_mapper #(
  parameter int WORDS_PER_PAGE = 64,
  parameter int NUM_PAGES      = 1024,
  parameter int EXT_W          = 8,
  localparam int WIP_W         = $clog2(WORDS_PER_PAGE),
  localparam int PAGE_W        = $clog2(NUM_PAGES),
  localparam int WA_W          = WIP_W + PAGE_W,
  localparam int BLK_W         = (WA_W + 1 > 15) ? (WA_W + 1 - 15) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cr_valid,
  output logic              cr_ready,
  input  logic [EXT_W-1:0]  cr_ext,
  input  logic [15:0]       cr_ptr,
  input  logic              dr_valid,
  output logic              dr_ready,
  input  logic [15:0]       dr_addr,
  input  logic [BLK_W-1:0]  dr_blk,
  output logic              dr_hit,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic              fl_rd_en,
  output logic [WA_W-1:0]   fl_rd_addr,
  input  logic [15:0]       fl_rd_data,
  input  logic              pg_start,
  input  logic [EXT_W-1:0]  pg_ext,
  input  logic [15:0]       pg_ptr,
  input  logic              pg_done,
  output logic              pg_busy,
  output logic [PAGE_W-1:0] pg_page,
  output logic [WIP_W-1:0]  pg_widx
);
  logic [WA_W-1:0]   c_word, d_word, p_word;
  logic              c_lane, d_lane, p_lane;
  logic [PAGE_W-1:0] c_page, p_page;
  logic [WIP_W-1:0]  c_widx, p_widx;
  logic              d_win;
  logic              d_ready_raw;
  logic              unused_ok;

  flmap_code_xlat #(.EXT_W(EXT_W), .WIP_W(WIP_W), .PAGE_W(PAGE_W)) u_code (
    .ext(cr_ext), .ptr(cr_ptr), .word_addr(c_word), .lane(c_lane),
    .page(c_page), .widx(c_widx));

  flmap_code_xlat #(.EXT_W(EXT_W), .WIP_W(WIP_W), .PAGE_W(PAGE_W)) u_pgx (
    .ext(pg_ext), .ptr(pg_ptr), .word_addr(p_word), .lane(p_lane),
    .page(p_page), .widx(p_widx));

  flmap_data_xlat #(.WA_W(WA_W), .BLK_W(BLK_W)) u_data (
    .addr(dr_addr), .blk(dr_blk), .in_win(d_win),
    .word_addr(d_word), .lane(d_lane));

  assign dr_hit    = dr_valid && d_win;
  assign unused_ok = ^{c_page, c_widx, p_word, p_lane};

  flmap_rd_stage #(.WA_W(WA_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .code_req(cr_valid), .code_word(c_word), .code_lane(c_lane),
    .data_req(dr_hit), .data_word(d_word), .data_lane(d_lane),
    .code_ready(cr_ready), .data_ready(d_ready_raw),
    .fl_rd_en(fl_rd_en), .fl_rd_addr(fl_rd_addr), .fl_rd_data(fl_rd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data));

  assign dr_ready = d_ready_raw && d_win;

  flmap_pg_latch #(.WIP_W(WIP_W), .PAGE_W(PAGE_W)) u_pg (
    .clk(clk), .rst_n(rst_n), .start(pg_start), .done(pg_done),
    .page_in(p_page), .widx_in(p_widx),
    .busy(pg_busy), .page_q(pg_page), .widx_q(pg_widx));

  a_r3_no_miss_read: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_valid && !dr_addr[15] && !cr_valid) |-> !fl_rd_en);
  a_r3_miss_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !dr_addr[15] |-> !dr_ready);
  a_r7_code_first: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_valid && dr_valid) |-> !dr_ready);
endmodule

// File: tb/sim_flash_addr_mapper.sv
`timescale 1ns/1ps
module sim_flash_addr_mapper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cr_valid = 0, dr_valid = 0, rsp_ready = 1;
  logic [7:0]  cr_ext = 0, pg_ext = 0;
  logic [15:0] cr_ptr = 0, dr_addr = 0, pg_ptr = 0;
  logic [1:0]  dr_blk = 0;
  logic        pg_start = 0, pg_done = 0;
  logic        cr_ready, dr_ready, dr_hit, rsp_valid, fl_rd_en, pg_busy;
  logic [7:0]  rsp_data;
  logic [15:0] fl_rd_addr;
  logic [15:0] fl_rd_data;
  logic [9:0]  pg_page;
  logic [5:0]  pg_widx;

  flash_addr_mapper u0 (.*);

  function automatic logic [15:0] fw(input logic [15:0] a);
    return (a * 16'h9E37) ^ 16'h5A3C;
  endfunction

  always_ff @(posedge clk)
    if (fl_rd_en) fl_rd_data <= fw(fl_rd_addr);

  int tests = 0, fails = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       stall = 0;
  int         cyc = 0;
  logic       was_stalled = 0;
  logic [7:0] last_data;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    rsp_ready = stall ? (cyc % 3 == 0) : 1'b1;
    if (rst_n) begin
      if (was_stalled) begin
        chk("R6 hold valid", rsp_valid, 1);
        chk("R6 hold data", rsp_data, last_data);
      end
      was_stalled = rsp_valid && !rsp_ready;
      last_data = rsp_data;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk("R6 unexpected response", 1, 0);
        else chk({tag_q.pop_front(), " rsp"}, rsp_data, exp_q.pop_front());
      end
    end
  end

  function automatic logic [7:0] exp_code(input logic [7:0] e, input logic [15:0] p);
    logic [23:0] f = {e, p};
    return f[0] ? fw(f[16:1])[15:8] : fw(f[16:1])[7:0];
  endfunction

  task automatic code_read(input logic [7:0] e, input logic [15:0] p, input string tag);
    logic [23:0] f = {e, p};
    @(negedge clk);
    cr_valid = 1; cr_ext = e; cr_ptr = p;
    forever begin
      #1;
      if (cr_ready) break;
      @(negedge clk);
    end
    chk({tag, " R1 word"}, fl_rd_addr, f[16:1]);
    exp_q.push_back(exp_code(e, p)); tag_q.push_back(tag);
    @(posedge clk); #1;
    chk("R5 valid after accept", rsp_valid, 1);
    cr_valid = 0;
  endtask

  task automatic data_read(input logic [1:0] b, input logic [15:0] a, input string tag);
    logic [16:0] off = {b, a[14:0]};
    @(negedge clk);
    dr_valid = 1; dr_addr = a; dr_blk = b;
    forever begin
      #1;
      if (dr_ready) break;
      @(negedge clk);
    end
    chk({tag, " R4 word"}, fl_rd_addr, off[16:1]);
    chk({tag, " R3 hit"}, dr_hit, 1);
    exp_q.push_back(off[0] ? fw(off[16:1])[15:8] : fw(off[16:1])[7:0]);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    dr_valid = 0;
  endtask

  task automatic pg_go(input logic [7:0] e, input logic [15:0] p);
    @(negedge clk); pg_start = 1; pg_ext = e; pg_ptr = p;
    @(negedge clk); pg_start = 0;
  endtask

  initial begin
    #1_500_000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("reset rsp_valid", rsp_valid, 0);
    chk("R8 reset busy", pg_busy, 0);
    chk("reset rd_en", fl_rd_en, 0);
    @(negedge clk); rst_n = 1;

    code_read(8'h00, 16'h1234, "R2 lane0");
    code_read(8'h00, 16'h1235, "R2 lane1");
    code_read(8'h01, 16'hFFFF, "R1 top");
    code_read(8'hFE, 16'h0042, "R1 ext ignore");
    code_read(8'h00, 16'h0000, "R1 zero");

    for (int b = 0; b < 4; b++) begin
      data_read(b[1:0], 16'h8000, "R4 win start");
      data_read(b[1:0], 16'hFFFF, "R4 win end");
      data_read(b[1:0], 16'h9ABD, "R4 mid");
    end

    // R3 misses
    @(negedge clk); dr_valid = 1; dr_addr = 16'h7FFF; dr_blk = 2'd3;
    #1;
    chk("R3 miss hit", dr_hit, 0);
    chk("R3 miss ready", dr_ready, 0);
    chk("R3 miss rd_en", fl_rd_en, 0);
    @(negedge clk); dr_addr = 16'h0000; #1;
    chk("R3 miss low rd_en", fl_rd_en, 0);
    @(negedge clk); dr_valid = 0;

    // R7 priority
    @(negedge clk);
    cr_valid = 1; cr_ext = 8'h00; cr_ptr = 16'h4447;
    dr_valid = 1; dr_addr = 16'hC001; dr_blk = 2'd1;
    #1;
    chk("R7 code ready", cr_ready, 1);
    chk("R7 data blocked", dr_ready, 0);
    chk("R7 code addr", fl_rd_addr, 16'h2223);
    exp_q.push_back(exp_code(8'h00, 16'h4447)); tag_q.push_back("R7 code");
    @(posedge clk); #1; cr_valid = 0;
    forever begin
      @(negedge clk); #1;
      if (dr_ready) break;
    end
    exp_q.push_back(fw(17'h0C001 >> 1)[15:8]); tag_q.push_back("R7 data");
    @(posedge clk); #1; dr_valid = 0;

    // R6 back-pressure, mixed order
    stall = 1;
    for (int i = 0; i < 12; i++) begin
      code_read(8'h00, 16'(i * 16'h0F13), "R6 code");
      data_read(2'(i), 16'(16'h8000 | (i * 16'h0777)), "R6 data");
    end
    stall = 0;
    repeat (6) @(negedge clk);
    chk("R6 queue drained", exp_q.size(), 0);

    // programming
    pg_go(8'h00, 16'h1A57);
    #1;
    chk("R8 busy", pg_busy, 1);
    chk("R8 page", pg_page, 10'((16'h1A57 >> 1) >> 6));
    chk("R8 widx", pg_widx, 6'((16'h1A57 >> 1) & 6'h3F));
    pg_go(8'h01, 16'hFFFE);
    #1;
    chk("R9 page kept", pg_page, 10'((16'h1A57 >> 1) >> 6));
    chk("R9 widx kept", pg_widx, 6'((16'h1A57 >> 1) & 6'h3F));
    chk("R9 busy kept", pg_busy, 1);
    @(negedge clk); pg_done = 1; @(negedge clk); pg_done = 0; #1;
    chk("R10 busy cleared", pg_busy, 0);
    pg_go(8'h01, 16'hFFFE);
    #1;
    chk("R10 relatch page", pg_page, 10'h3FF);
    chk("R10 relatch widx", pg_widx, 6'h3F);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule